// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

A fully associative store of page translations. Each slot keeps a virtual page number tag, the number of the address space that owns it, a global flag, a physical page number, one read-enable and one write-enable bit per privilege mode, and two fault-on-access flags (read and write). A request made of a page number and an address-space number is matched against every slot in the same cycle. The result is a one-hot hit vector, the index of the winning slot and that slot's fields.

Slots are filled in round-robin order from a single victim pointer. The current victim slot is always visible on a separate group of outputs, so refill logic can read or rewrite it. One command port carries insert, flush-all, flush of non-global slots, flush of one address and a victim-index step. Every command takes effect on the rising clock edge. The slot count is a parameter; the default of 48 suits instruction-side use, and 64 suits data-side use.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose stored space number equals `lk_asn`. On a miss `lk_hit` is 0 and every `lk_*` field output is zero.
- R2: When several slots match, the lowest-index slot wins. `lk_hit_vec` has exactly that one bit set, and `lk_index` holds its index.
- R3: `cmd_op` = 3'd1 (insert) writes `cmd_vpn`, `cmd_asn` and the `ins_*` fields into the slot at `vic_ptr` and marks it valid, replacing whatever that slot held.
- R4: Each insert advances `vic_ptr` by one. After slot `ENTRIES`-1 the pointer returns to 0.
- R5: `cmd_op` = 3'd2 (flush-all) zeroes every slot, valid flags and fields alike, and sets `vic_ptr` to 0.
- R6: `cmd_op` = 3'd3 invalidates every slot whose global flag is clear. Global slots and the pointer are left unchanged.
- R7: `cmd_op` = 3'd4 invalidates every slot that a lookup of (`cmd_vpn`, `cmd_asn`) would match under the R1 rule. This includes every matching slot, not only the first.
- R8: The `vic_*` outputs always show the slot at `vic_ptr`. `cmd_op` = 3'd5 (index) advances the pointer only when `vic_advance` is 1. Codes 3'd0, 3'd6 and 3'd7 change nothing.
- R9: A synchronous active-low `rst_n` has the same effect as flush-all.
- R10: The slot count `ENTRIES` is a parameter of at least 2. All `ENTRIES` slots hold distinct translations at once, and lookups read the current contents without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_hit_vec | output | ENTRIES | One-hot winning slot |
| lk_index | output | $clog2(ENTRIES) | Index of the winning slot |
| lk_ppn | output | PPN_W | Physical page of the winner |
| lk_glb | output | 1 | Global flag of the winner |
| lk_ent_asn | output | ASN_W | Stored space number of the winner |
| lk_rd_en | output | MODE_N | Per-mode read enables of the winner |
| lk_wr_en | output | MODE_N | Per-mode write enables of the winner |
| lk_fault_rd | output | 1 | Fault-on-read flag of the winner |
| lk_fault_wr | output | 1 | Fault-on-write flag of the winner |
| cmd_op | input | 3 | Command code (see R3 to R8) |
| cmd_vpn | input | VPN_W | Page number for insert and address flush |
| cmd_asn | input | ASN_W | Space number for insert and address flush |
| ins_ppn | input | PPN_W | Physical page for insert |
| ins_glb | input | 1 | Global flag for insert |
| ins_rd_en | input | MODE_N | Read enables for insert |
| ins_wr_en | input | MODE_N | Write enables for insert |
| ins_fault_rd | input | 1 | Fault-on-read flag for insert |
| ins_fault_wr | input | 1 | Fault-on-write flag for insert |
| vic_advance | input | 1 | Step the pointer on an index command |
| vic_ptr | output | $clog2(ENTRIES) | Victim pointer |
| vic_valid | output | 1 | Valid flag of the victim slot |
| vic_vpn | output | VPN_W | Tag of the victim slot |
| vic_asn | output | ASN_W | Space number of the victim slot |
| vic_glb | output | 1 | Global flag of the victim slot |
| vic_ppn | output | PPN_W | Physical page of the victim slot |
| vic_rd_en | output | MODE_N | Read enables of the victim slot |
| vic_wr_en | output | MODE_N | Write enables of the victim slot |
| vic_fault_rd | output | 1 | Fault-on-read flag of the victim slot |
| vic_fault_wr | output | 1 | Fault-on-write flag of the victim slot |

## Verification
A wrongly stored slot or a valid flag left set shows up at the next lookup of that page, which returns a hit when it should miss or returns the wrong fields. A fault in the victim pointer is visible on `vic_ptr` in the cycle after the insert or index command that moved it. A flush that drops too much or too little is seen in the first cycle after the flush, on whichever page the lookup inputs then select. The slots themselves are only observable through the lookup and victim outputs. For that reason the bench compares both groups against its model in every cycle, so any divergence appears within one clock.

// File: rtl/asn_tlb_pkg.sv
`timescale 1ns/1ps
package asn_tlb_pkg;

   typedef enum logic [2:0] {
      TLB_IDLE        = 3'd0,
      TLB_INSERT      = 3'd1,
      TLB_FLUSH_ALL   = 3'd2,
      TLB_FLUSH_LOCAL = 3'd3,
      TLB_FLUSH_ADDR  = 3'd4,
      TLB_INDEX       = 3'd5
   } tlb_op_e;

endpackage

// File: rtl/asn_tlb_match.sv
`timescale 1ns/1ps
// Per-slot comparator bank: tag equal and (global or same space number).
module asn_tlb_match #(
   parameter int N     = 48,
   parameter int VPN_W = 20,
   parameter int ASN_W = 8
) (
   input  logic [N-1:0]     ent_v,
   input  logic [N-1:0]     ent_g,
   input  logic [VPN_W-1:0] ent_tag [N],
   input  logic [ASN_W-1:0] ent_asn [N],
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [ASN_W-1:0] req_asn,
   output logic [N-1:0]     match
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      logic tag_eq;
      logic asn_ok;
      assign tag_eq   = (ent_tag[g] == req_vpn);
      assign asn_ok   = ent_g[g] || (ent_asn[g] == req_asn);
      assign match[g] = ent_v[g] && tag_eq && asn_ok;
   end

endmodule

// File: rtl/asn_tlb_first.sv
`timescale 1ns/1ps
// Lowest-index winner of a request vector, as one-hot and as binary index.
module asn_tlb_first #(
   parameter int N = 48,
   localparam int IDX_W = (N < 2) ? 1 : $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     onehot,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign onehot = req & (~req + N'(1));
   assign any    = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/asn_tlb_victim.sv
`timescale 1ns/1ps
// Round-robin victim pointer; power-of-two sizes wrap for free.
module asn_tlb_victim #(
   parameter int N = 48,
   localparam int IDX_W = (N < 2) ? 1 : $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] nxt;

   if ((1 << IDX_W) == N) begin : g_pow2
      assign nxt = ptr + IDX_W'(1);
   end else begin : g_wrap
      assign nxt = (ptr == IDX_W'(N - 1)) ? '0 : ptr + IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) ptr <= '0;
      else if (step)       ptr <= nxt;
   end

endmodule

// File: rtl/asn_tlb.sv
`timescale 1ns/1ps
module asn_tlb #(
   parameter int ENTRIES = 48,
   parameter int VPN_W   = 20,
   parameter int ASN_W   = 8,
   parameter int PPN_W   = 24,
   parameter int MODE_N  = 4,
   localparam int IDX_W  = (ENTRIES < 2) ? 1 : $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_hit,
   output logic [ENTRIES-1:0] lk_hit_vec,
   output logic [IDX_W-1:0]  lk_index,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic              lk_glb,
   output logic [ASN_W-1:0]  lk_ent_asn,
   output logic [MODE_N-1:0] lk_rd_en,
   output logic [MODE_N-1:0] lk_wr_en,
   output logic              lk_fault_rd,
   output logic              lk_fault_wr,
   input  logic [2:0]        cmd_op,
   input  logic [VPN_W-1:0]  cmd_vpn,
   input  logic [ASN_W-1:0]  cmd_asn,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic              ins_glb,
   input  logic [MODE_N-1:0] ins_rd_en,
   input  logic [MODE_N-1:0] ins_wr_en,
   input  logic              ins_fault_rd,
   input  logic              ins_fault_wr,
   input  logic              vic_advance,
   output logic [IDX_W-1:0]  vic_ptr,
   output logic              vic_valid,
   output logic [VPN_W-1:0]  vic_vpn,
   output logic [ASN_W-1:0]  vic_asn,
   output logic              vic_glb,
   output logic [PPN_W-1:0]  vic_ppn,
   output logic [MODE_N-1:0] vic_rd_en,
   output logic [MODE_N-1:0] vic_wr_en,
   output logic              vic_fault_rd,
   output logic              vic_fault_wr
);
   import asn_tlb_pkg::*;

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("asn_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || ASN_W < 1 || PPN_W < 1 || MODE_N < 1) begin : g_bad_width
      $error("asn_tlb: field widths must be positive");
   end

   tlb_op_e op;
   logic    do_insert, do_flush_all, do_flush_local, do_flush_addr, do_step;

   assign op             = tlb_op_e'(cmd_op);
   assign do_insert      = (op == TLB_INSERT);
   assign do_flush_all   = (op == TLB_FLUSH_ALL);
   assign do_flush_local = (op == TLB_FLUSH_LOCAL);
   assign do_flush_addr  = (op == TLB_FLUSH_ADDR);
   assign do_step        = do_insert || ((op == TLB_INDEX) && vic_advance);

   // slot state, gathered from the per-slot registers
   logic [ENTRIES-1:0] v_vec;
   logic [ENTRIES-1:0] g_vec;
   logic [VPN_W-1:0]   tag_a  [ENTRIES];
   logic [ASN_W-1:0]   asn_a  [ENTRIES];
   logic [PPN_W-1:0]   ppn_a  [ENTRIES];
   logic [MODE_N-1:0]  rd_a   [ENTRIES];
   logic [MODE_N-1:0]  wr_a   [ENTRIES];
   logic [ENTRIES-1:0] frd_vec;
   logic [ENTRIES-1:0] fwr_vec;

   logic [ENTRIES-1:0] fa_match;

   asn_tlb_victim #(.N(ENTRIES)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (do_flush_all),
      .step  (do_step),
      .ptr   (vic_ptr)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic              v_r, g_r, frd_r, fwr_r;
      logic [VPN_W-1:0]  tag_r;
      logic [ASN_W-1:0]  asn_r;
      logic [PPN_W-1:0]  ppn_r;
      logic [MODE_N-1:0] rd_r, wr_r;
      logic              wr_here, drop_here;

      assign wr_here   = do_insert && (vic_ptr == IDX_W'(g));
      assign drop_here = (do_flush_local && !g_r) || (do_flush_addr && fa_match[g]);

      always_ff @(posedge clk) begin
         if (!rst_n || do_flush_all) begin
            v_r   <= 1'b0;
            g_r   <= 1'b0;
            tag_r <= '0;
            asn_r <= '0;
            ppn_r <= '0;
            rd_r  <= '0;
            wr_r  <= '0;
            frd_r <= 1'b0;
            fwr_r <= 1'b0;
         end else if (wr_here) begin
            v_r   <= 1'b1;
            g_r   <= ins_glb;
            tag_r <= cmd_vpn;
            asn_r <= cmd_asn;
            ppn_r <= ins_ppn;
            rd_r  <= ins_rd_en;
            wr_r  <= ins_wr_en;
            frd_r <= ins_fault_rd;
            fwr_r <= ins_fault_wr;
         end else if (drop_here) begin
            v_r   <= 1'b0;
         end
      end

      assign v_vec[g]   = v_r;
      assign g_vec[g]   = g_r;
      assign tag_a[g]   = tag_r;
      assign asn_a[g]   = asn_r;
      assign ppn_a[g]   = ppn_r;
      assign rd_a[g]    = rd_r;
      assign wr_a[g]    = wr_r;
      assign frd_vec[g] = frd_r;
      assign fwr_vec[g] = fwr_r;
   end

   // lookup path
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;

   asn_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
      .ent_v   (v_vec),
      .ent_g   (g_vec),
      .ent_tag (tag_a),
      .ent_asn (asn_a),
      .req_vpn (lk_vpn),
      .req_asn (lk_asn),
      .match   (lk_match)
   );

   asn_tlb_first #(.N(ENTRIES)) u_first (
      .req    (lk_match),
      .onehot (lk_hit_vec),
      .any    (lk_any),
      .idx    (lk_index)
   );

   // flush-by-address uses the same rule on the command fields
   asn_tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fa_match (
      .ent_v   (v_vec),
      .ent_g   (g_vec),
      .ent_tag (tag_a),
      .ent_asn (asn_a),
      .req_vpn (cmd_vpn),
      .req_asn (cmd_asn),
      .match   (fa_match)
   );

   assign lk_hit = lk_any;

   always_comb begin
      lk_ppn      = '0;
      lk_glb      = 1'b0;
      lk_ent_asn  = '0;
      lk_rd_en    = '0;
      lk_wr_en    = '0;
      lk_fault_rd = 1'b0;
      lk_fault_wr = 1'b0;
      if (lk_any) begin
         lk_ppn      = ppn_a[lk_index];
         lk_glb      = g_vec[lk_index];
         lk_ent_asn  = asn_a[lk_index];
         lk_rd_en    = rd_a[lk_index];
         lk_wr_en    = wr_a[lk_index];
         lk_fault_rd = frd_vec[lk_index];
         lk_fault_wr = fwr_vec[lk_index];
      end
   end

   // victim slot view
   assign vic_valid    = v_vec[vic_ptr];
   assign vic_vpn      = tag_a[vic_ptr];
   assign vic_asn      = asn_a[vic_ptr];
   assign vic_glb      = g_vec[vic_ptr];
   assign vic_ppn      = ppn_a[vic_ptr];
   assign vic_rd_en    = rd_a[vic_ptr];
   assign vic_wr_en    = wr_a[vic_ptr];
   assign vic_fault_rd = frd_vec[vic_ptr];
   assign vic_fault_wr = fwr_vec[vic_ptr];

endmodule

// File: rtl/asn_tlb_chk.sv
`timescale 1ns/1ps
module asn_tlb_chk #(
   parameter int N     = 48,
   parameter int ASN_W = 8,
   localparam int IDX_W = (N < 2) ? 1 : $clog2(N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cmd_op,
   input logic             vic_advance,
   input logic [ASN_W-1:0] lk_asn,
   input logic             lk_hit,
   input logic [N-1:0]     lk_hit_vec,
   input logic             lk_glb,
   input logic [ASN_W-1:0] lk_ent_asn,
   input logic [IDX_W-1:0] vic_ptr,
   input logic             vic_valid,
   input logic             vic_glb
);

   p_space_rule_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_glb || (lk_ent_asn == lk_asn)));

   p_vec_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec));

   p_hit_vec_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit == (lk_hit_vec != '0));

   p_insert_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd1) |=> (vic_ptr == (($past(vic_ptr) == IDX_W'(N - 1)) ? '0
                                        : $past(vic_ptr) + IDX_W'(1))));

   p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd2) |=> (vic_ptr == '0) && !vic_valid);

   p_local_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd3) |=> (!vic_valid || vic_glb));

   p_index_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_op == 3'd5) && !vic_advance) |=> $stable(vic_ptr));

   p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |=> (vic_ptr == '0) && !vic_valid);

endmodule

bind asn_tlb asn_tlb_chk #(.N(ENTRIES), .ASN_W(ASN_W)) u_asn_tlb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_op      (cmd_op),
   .vic_advance (vic_advance),
   .lk_asn      (lk_asn),
   .lk_hit      (lk_hit),
   .lk_hit_vec  (lk_hit_vec),
   .lk_glb      (lk_glb),
   .lk_ent_asn  (lk_ent_asn),
   .vic_ptr     (vic_ptr),
   .vic_valid   (vic_valid),
   .vic_glb     (vic_glb)
);

// File: tb/test_asn_tlb.sv
`timescale 1ns/1ps
module test_asn_tlb;
   localparam int N      = 48;
   localparam int VPN_W  = 20;
   localparam int ASN_W  = 8;
   localparam int PPN_W  = 24;
   localparam int MODE_N = 4;
   localparam int IDX_W  = $clog2(N);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n = 1'b0;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic [ASN_W-1:0]  lk_asn = '0;
   logic              lk_hit;
   logic [N-1:0]      lk_hit_vec;
   logic [IDX_W-1:0]  lk_index;
   logic [PPN_W-1:0]  lk_ppn;
   logic              lk_glb;
   logic [ASN_W-1:0]  lk_ent_asn;
   logic [MODE_N-1:0] lk_rd_en, lk_wr_en;
   logic              lk_fault_rd, lk_fault_wr;
   logic [2:0]        cmd_op = 3'd0;
   logic [VPN_W-1:0]  cmd_vpn = '0;
   logic [ASN_W-1:0]  cmd_asn = '0;
   logic [PPN_W-1:0]  ins_ppn = '0;
   logic              ins_glb = 1'b0;
   logic [MODE_N-1:0] ins_rd_en = '0, ins_wr_en = '0;
   logic              ins_fault_rd = 1'b0, ins_fault_wr = 1'b0;
   logic              vic_advance = 1'b0;
   logic [IDX_W-1:0]  vic_ptr;
   logic              vic_valid;
   logic [VPN_W-1:0]  vic_vpn;
   logic [ASN_W-1:0]  vic_asn;
   logic              vic_glb;
   logic [PPN_W-1:0]  vic_ppn;
   logic [MODE_N-1:0] vic_rd_en, vic_wr_en;
   logic              vic_fault_rd, vic_fault_wr;

   asn_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W), .MODE_N(MODE_N)) i_asn_tlb (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
      .lk_hit(lk_hit), .lk_hit_vec(lk_hit_vec), .lk_index(lk_index), .lk_ppn(lk_ppn),
      .lk_glb(lk_glb), .lk_ent_asn(lk_ent_asn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
      .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
      .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .ins_ppn(ins_ppn),
      .ins_glb(ins_glb), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
      .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr), .vic_advance(vic_advance),
      .vic_ptr(vic_ptr), .vic_valid(vic_valid), .vic_vpn(vic_vpn), .vic_asn(vic_asn),
      .vic_glb(vic_glb), .vic_ppn(vic_ppn), .vic_rd_en(vic_rd_en), .vic_wr_en(vic_wr_en),
      .vic_fault_rd(vic_fault_rd), .vic_fault_wr(vic_fault_wr)
   );

   // behavioural reference model
   bit                m_v   [N];
   bit                m_g   [N];
   logic [VPN_W-1:0]  m_tag [N];
   logic [ASN_W-1:0]  m_asn [N];
   logic [PPN_W-1:0]  m_ppn [N];
   logic [MODE_N-1:0] m_rd  [N];
   logic [MODE_N-1:0] m_wr  [N];
   bit                m_fr  [N];
   bit                m_fw  [N];
   int                m_ptr = 0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit hits(input int i, input logic [VPN_W-1:0] vp, input logic [ASN_W-1:0] as);
      return m_v[i] && (m_tag[i] == vp) && (m_g[i] || (m_asn[i] == as));
   endfunction

   function automatic logic [63:0] fields(input int i);
      return {21'd0, m_ppn[i], m_g[i], m_asn[i], m_rd[i], m_wr[i], m_fr[i], m_fw[i]};
   endfunction

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_g[i] = 0; m_tag[i] = '0; m_asn[i] = '0; m_ppn[i] = '0;
         m_rd[i] = '0; m_wr[i] = '0; m_fr[i] = 0; m_fw[i] = 0;
      end
      m_ptr = 0;
   endtask

   // compare all outputs against the model, then let one edge pass
   task automatic tick(input string req);
      int first;
      logic [N-1:0] ev;
      logic [63:0] ef, af, vf;
      #1;
      first = -1;
      for (int i = 0; i < N; i++) if (first < 0 && hits(i, lk_vpn, lk_asn)) first = i;
      ev = '0;
      ef = '0;
      if (first >= 0) begin ev[first] = 1'b1; ef = fields(first); end
      af = {21'd0, lk_ppn, lk_glb, lk_ent_asn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr};
      check(lk_hit == (first >= 0), req, "lk_hit (R1)", 64'(lk_hit), 64'(first >= 0));
      check(lk_hit_vec == ev, req, "lk_hit_vec (R2)", 64'(lk_hit_vec), 64'(ev));
      if (first >= 0)
         check(int'(lk_index) == first, req, "lk_index (R2)", 64'(lk_index), 64'(first));
      check(af == ef, req, "lookup fields (R1)", af, ef);
      check(int'(vic_ptr) == m_ptr, req, "vic_ptr (R4)", 64'(vic_ptr), 64'(m_ptr));
      vf = {vic_valid, vic_vpn, vic_ppn, vic_glb, vic_asn, vic_rd_en, vic_wr_en, vic_fault_rd, vic_fault_wr};
      ef = {m_v[m_ptr], m_tag[m_ptr], fields(m_ptr)[42:0]};
      check(vf == ef, req, "victim view (R8)", vf, ef);
      @(posedge clk);
      if (!rst_n) model_clear();
      else begin
         case (cmd_op)
            3'd1: begin
               m_v[m_ptr] = 1; m_g[m_ptr] = ins_glb; m_tag[m_ptr] = cmd_vpn;
               m_asn[m_ptr] = cmd_asn; m_ppn[m_ptr] = ins_ppn; m_rd[m_ptr] = ins_rd_en;
               m_wr[m_ptr] = ins_wr_en; m_fr[m_ptr] = ins_fault_rd; m_fw[m_ptr] = ins_fault_wr;
               m_ptr = (m_ptr + 1) % N;
            end
            3'd2: model_clear();
            3'd3: for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 0;
            3'd4: begin
               bit kill [N];
               for (int i = 0; i < N; i++) kill[i] = hits(i, cmd_vpn, cmd_asn);
               for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
            end
            3'd5: if (vic_advance) m_ptr = (m_ptr + 1) % N;
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic ins(input int vp, input int as, input bit g, input int pp, input string req);
      cmd_op = 3'd1; cmd_vpn = VPN_W'(vp); cmd_asn = ASN_W'(as); ins_glb = g;
      ins_ppn = PPN_W'(pp); ins_rd_en = MODE_N'(pp); ins_wr_en = MODE_N'(pp >> 4);
      ins_fault_rd = pp[0]; ins_fault_wr = pp[1];
      tick(req);
      cmd_op = 3'd0;
   endtask

   task automatic op(input logic [2:0] code, input int vp, input int as, input bit adv, input string req);
      cmd_op = code; cmd_vpn = VPN_W'(vp); cmd_asn = ASN_W'(as); vic_advance = adv;
      tick(req);
      cmd_op = 3'd0; vic_advance = 1'b0;
   endtask

   task automatic look(input int vp, input int as, input string req);
      lk_vpn = VPN_W'(vp); lk_asn = ASN_W'(as);
      tick(req);
   endtask

   initial begin
      model_clear();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      look(0, 0, "R9 reset state");
      rst_n = 1'b1;
      look(0, 0, "R9 after reset");

      // basic inserts and matching
      ins('h100, 1, 0, 'h0A1, "R3");
      ins('h200, 2, 1, 'h0B2, "R3");
      ins('h100, 3, 0, 'h0C3, "R3");
      ins('h100, 1, 0, 'h0D4, "R3");
      look('h100, 1, "R2 lowest index wins");
      look('h100, 3, "R1 space match");
      look('h100, 5, "R1 space mismatch");
      look('h200, 9, "R1 global hit");
      look('h300, 1, "R1 tag miss");

      // flush by address removes both duplicates
      lk_vpn = VPN_W'('h100); lk_asn = ASN_W'(1);
      op(3'd4, 'h100, 1, 0, "R7 flush address");
      look('h100, 1, "R7 duplicates gone");
      look('h100, 3, "R7 other space kept");
      op(3'd4, 'h200, 7, 0, "R7 global flushed by address");
      look('h200, 2, "R7 global gone");

      // flush non-global
      ins('h300, 4, 1, 'h0E5, "R3");
      op(3'd3, 0, 0, 0, "R6 flush local");
      look('h100, 3, "R6 local gone");
      look('h300, 0, "R6 global kept");

      // index command
      op(3'd5, 0, 0, 0, "R8 index hold");
      op(3'd5, 0, 0, 0, "R8 index hold again");
      op(3'd5, 0, 0, 1, "R8 index advance");
      op(3'd6, 'h300, 0, 1, "R8 unused code");
      look('h300, 0, "R8 unused code no effect");

      // fill past capacity
      for (int i = 0; i < N + 4; i++) ins('h1000 + i, 0, 0, 'h2000 + i, "R4 R10 fill");
      for (int i = 0; i < N + 4; i++) look('h1000 + i, 0, "R10 R3 all slots");

      // flush all
      op(3'd2, 0, 0, 0, "R5 flush all");
      look('h1010, 0, "R5 empty after flush");
      look('h300, 0, "R5 global cleared");

      // mid-run reset
      ins('h55, 1, 1, 'h99, "R3");
      ins('h56, 1, 0, 'h98, "R3");
      rst_n = 1'b0;
      look('h55, 1, "R9 reset pending");
      rst_n = 1'b1;
      look('h55, 1, "R9 reset cleared");

      // mixed traffic over a small page and space range
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = $urandom_range(0, 99);
         lk_vpn = VPN_W'($urandom_range(0, 7));
         lk_asn = ASN_W'($urandom_range(0, 3));
         if (r < 55)      ins($urandom_range(0, 7), $urandom_range(0, 3), ($urandom_range(0, 3) == 0), $urandom_range(0, 'hFFFF), "R3 R4 mixed");
         else if (r < 65) op(3'd4, $urandom_range(0, 7), $urandom_range(0, 3), 0, "R7 mixed");
         else if (r < 68) op(3'd3, 0, 0, 0, "R6 mixed");
         else if (r < 69) op(3'd2, 0, 0, 0, "R5 mixed");
         else if (r < 78) op(3'd5, 0, 0, ($urandom_range(0, 1) == 1), "R8 mixed");
         else             tick("R1 R2 mixed");
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule